// File: doc/BRIEF.md
# Machine-Mode Trap Entry Controller

This block holds the pending trap requests of a small processor core and performs machine-mode trap entry. Requests arrive on an external request port, and a built-in 64-bit timer comparator adds its own. They are kept in a four-entry last-in-first-out store. When the global interrupt enable is set and at least one request is waiting, the controller takes the most recently queued one in a single cycle. In that cycle it does four things:

- saves the enable and the current privilege into the status fields and clears the enable;
- records the cause, the current PC and the trap value;
- reports machine privilege;
- issues a one-cycle redirect to a PC derived from the trap-vector register.

Software configures the vector register, the status fields and the timer compare value through a small CSR port. The core supplies its current PC and privilege level every cycle and follows the redirect strobe. The timer counts input clocks in groups of `TICK_DIV` and arms itself whenever a compare half is written.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A trap is taken only when the queue is non-empty and the enable `mie_o` is 1. Taking it raises `trap_taken` for exactly one cycle, on the clock edge after both conditions hold. With an empty queue, or with the enable at 0, `trap_taken` stays 0.
- R2: On entry, `mpie_o` gets the old enable value, `mpp_o` gets `cur_priv` as sampled at the taking edge, and `mie_o` becomes 0.
- R3: On entry, `mepc_o` gets `cur_pc`. `mtval_o` gets the request's tval. `mcause_o` gets `{is_irq, cause[30:0]}`, with the interrupt flag in bit 31.
- R4: `redirect_priv` reads 2'b11 (machine) whenever `trap_taken` is 1.
- R5: When the vector register's bits [1:0] are 0, 2 or 3, `redirect_pc` equals the whole vector register value.
- R6: When the vector register's bits [1:0] are 1, `redirect_pc` equals the register with bits [1:0] cleared, plus 4 times the 5-bit trap code.
- R7: While armed, the timer queues a request with is_irq=1, code 7, cause 7 and tval 0 once the compare value is strictly below `mtime_o`. It then disarms and raises no further request until it is re-armed.
- R8: `mtime_o` is 0 at reset and increases by one every `TICK_DIV` clock cycles (3 by default).
- R9: A write to either half of the compare value sets `timer_armed_o` on that write's clock edge. The armed flag is 0 after reset.
- R10: When several requests are pending, they are taken in reverse order of arrival.
- R11: The queue holds 4 entries. A request arriving while the queue is full is discarded and sets `overflow_o`. `overflow_o` then stays 1 until reset. The 4 entries already queued are unaffected.
- R12: CSR select codes are 0 for the vector register, 1 for status, 2 for the low compare half and 3 for the high compare half. In status, the enable is bit 3, the previous enable is bit 7 and the previous privilege is bits [12:11]. Writes take effect on the clock edge, and `csr_rdata` returns the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | PC of the instruction being interrupted |
| cur_priv | input | 2 | Current privilege encoding |
| req_valid | input | 1 | External trap request strobe |
| req_irq | input | 1 | Request is an interrupt |
| req_code | input | 5 | Trap code used for vectoring |
| req_cause | input | 31 | Cause value without the interrupt flag |
| req_tval | input | 32 | Trap value |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 2 | CSR select |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data |
| trap_taken | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Handler address |
| redirect_priv | output | 2 | Privilege after entry |
| mcause_o | output | 32 | Recorded cause |
| mepc_o | output | 32 | Recorded exception PC |
| mtval_o | output | 32 | Recorded trap value |
| mie_o | output | 1 | Global interrupt enable |
| mpie_o | output | 1 | Previous interrupt enable |
| mpp_o | output | 2 | Previous privilege |
| timer_armed_o | output | 1 | Timer compare armed |
| overflow_o | output | 1 | Sticky queue overflow |
| mtime_o | output | 64 | Timer count |

## Verification
A corrupted queue pointer or a wrong entry shows at the next taken trap. It appears as a wrong cause, code-derived handler address or trap value on the strobe cycle, one edge after the enable is written. A stale enable or a broken disarm shows as a strobe that appears when it must not, or that fails to appear within a cycle. Timer faults show up as a count that drifts from one increment per `TICK_DIV` cycles, or as the armed flag dropping before the count passes the compare value. Mixing random request bursts with random vector modes drains the queue in many orders. Each drained entry is compared with a model stack kept in the bench.

// File: rtl/trap_pkg.sv
// Shared constants and the queued trap record for the trap entry controller.
// Assumes a 32-bit machine word and 5-bit trap codes.
package trap_pkg;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;

    localparam logic [1:0] PRIV_MACH = 2'b11;
    localparam logic [1:0] VEC_MODE  = 2'b01;

    localparam logic [1:0] SEL_TVEC   = 2'd0;
    localparam logic [1:0] SEL_STATUS = 2'd1;
    localparam logic [1:0] SEL_CMP_LO = 2'd2;
    localparam logic [1:0] SEL_CMP_HI = 2'd3;

    localparam int EN_BIT     = 3;
    localparam int PREV_EN_BIT = 7;
    localparam int PREV_PRIV_LSB = 11;

    localparam logic [CODE_W-1:0] TIMER_CODE = CODE_W'(7);

    typedef struct packed {
        logic              is_irq;
        logic [CODE_W-1:0] code;
        logic [XLEN-2:0]   cause;
        logic [XLEN-1:0]   tval;
    } trap_rec_t;
endpackage

// File: rtl/trap_lifo.sv
// Pending trap store: last in, first out, DEPTH entries.
// Assumes at most one pop and two pushes per cycle; the pop applies to the old top,
// then push_a and push_b enter in that order. A push into a full store is dropped
// and sets the sticky overflow flag.
module trap_lifo
    import trap_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pop,
    input  logic      push_a,
    input  trap_rec_t rec_a,
    input  logic      push_b,
    input  trap_rec_t rec_b,
    output trap_rec_t top_o,
    output logic      nonempty_o,
    output logic      overflow_o
);
    localparam int CW = $clog2(DEPTH + 1);

    trap_rec_t      slot_q [DEPTH];
    trap_rec_t      slot_n [DEPTH];
    logic [CW-1:0]  cnt_q, cnt_n;
    logic           ovf_q, ovf_n;

    // Next-state of the store: pop first, then the two pushes in order.
    always_comb begin
        slot_n = slot_q;
        cnt_n  = cnt_q;
        ovf_n  = ovf_q;
        if (pop && cnt_n != '0) cnt_n = cnt_n - CW'(1);
        if (push_a) begin
            if (cnt_n < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == cnt_n) slot_n[i] = rec_a;
                cnt_n = cnt_n + CW'(1);
            end else begin
                ovf_n = 1'b1;
            end
        end
        if (push_b) begin
            if (cnt_n < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == cnt_n) slot_n[i] = rec_b;
                cnt_n = cnt_n + CW'(1);
            end else begin
                ovf_n = 1'b1;
            end
        end
    end

    // Register the store, its fill count and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            cnt_q  <= cnt_n;
            ovf_q  <= ovf_n;
            slot_q <= slot_n;
        end
    end

    // Select the most recently stored entry.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i + 1) == cnt_q) top_o = slot_q[i];
    end

    assign nonempty_o = (cnt_q != '0);
    assign overflow_o = ovf_q;
endmodule

// File: rtl/trap_timer.sv
// Timer source: a 64-bit count advancing once per TICK_DIV clocks, a 64-bit compare
// value written in halves, and an armed flag. Fires a one-cycle request when armed
// and the compare value is strictly below the count, then disarms. A compare write
// re-arms and suppresses firing in that cycle.
module trap_timer
    import trap_pkg::*;
#(
    parameter int TICK_DIV = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [XLEN-1:0] wdata,
    output logic [63:0]     count_o,
    output logic [63:0]     cmp_o,
    output logic            armed_o,
    output logic            fire_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] pre_q;
    logic [63:0]   count_q, cmp_q;
    logic          armed_q;
    logic          tick, cmp_wr;

    assign tick   = (pre_q == PW'(TICK_DIV - 1));
    assign cmp_wr = wr_lo | wr_hi;
    assign fire_o = armed_q && (cmp_q < count_q) && !cmp_wr;

    // Prescaler and time count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            count_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + PW'(1);
            if (tick) count_q <= count_q + 64'd1;
        end
    end

    // Compare value halves and the arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q   <= '1;
            armed_q <= 1'b0;
        end else begin
            if (wr_lo) cmp_q[31:0]  <= wdata;
            if (wr_hi) cmp_q[63:32] <= wdata;
            if (cmp_wr)      armed_q <= 1'b1;
            else if (fire_o) armed_q <= 1'b0;
        end
    end

    assign count_o = count_q;
    assign cmp_o   = cmp_q;
    assign armed_o = armed_q;
endmodule

// File: rtl/trap_vector.sv
// Handler address from the vector register: mode 1 adds four times the code to
// the aligned base; modes 0, 2 and 3 use the register value unchanged.
module trap_vector
    import trap_pkg::*;
(
    input  logic [XLEN-1:0]   tvec,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   pc_o
);
    logic [XLEN-1:0] base;
    assign base = {tvec[XLEN-1:2], 2'b00};

    // Choose vectored or direct target.
    always_comb begin
        if (tvec[1:0] == VEC_MODE) pc_o = base + (XLEN'(code) << 2);
        else                       pc_o = tvec;
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
// Machine-mode trap entry controller. Queues external and timer requests in a LIFO
// and, when the global enable is set and something is pending, performs the whole
// entry (status save, cause/epc/tval capture, privilege switch, redirect) in one
// clock edge. Assumes the core samples trap_taken and redirect_pc on the following
// cycle and that cur_pc/cur_priv are valid every cycle.
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int TICK_DIV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_priv,
    input  logic              req_valid,
    input  logic              req_irq,
    input  logic [CODE_W-1:0] req_code,
    input  logic [XLEN-2:0]   req_cause,
    input  logic [XLEN-1:0]   req_tval,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              trap_taken,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [1:0]        redirect_priv,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mtval_o,
    output logic              mie_o,
    output logic              mpie_o,
    output logic [1:0]        mpp_o,
    output logic              timer_armed_o,
    output logic              overflow_o,
    output logic [63:0]       mtime_o
);
    logic [XLEN-1:0] mtvec_q;
    logic [63:0]     tcmp_q;
    logic            en_q, prev_en_q;
    logic [1:0]      prev_priv_q;
    logic            take, pending, timer_fire;
    trap_rec_t       ext_rec, tmr_rec, top_rec;
    logic [XLEN-1:0] vec_pc;

    assign ext_rec = '{is_irq: req_irq, code: req_code, cause: req_cause, tval: req_tval};
    assign tmr_rec = '{is_irq: 1'b1, code: TIMER_CODE, cause: (XLEN-1)'(TIMER_CODE), tval: '0};
    assign take    = pending && en_q;

    trap_lifo #(.DEPTH(DEPTH)) lifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (take),
        .push_a     (req_valid),
        .rec_a      (ext_rec),
        .push_b     (timer_fire),
        .rec_b      (tmr_rec),
        .top_o      (top_rec),
        .nonempty_o (pending),
        .overflow_o (overflow_o)
    );

    trap_timer #(.TICK_DIV(TICK_DIV)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (csr_we && csr_sel == SEL_CMP_LO),
        .wr_hi   (csr_we && csr_sel == SEL_CMP_HI),
        .wdata   (csr_wdata),
        .count_o (mtime_o),
        .cmp_o   (tcmp_q),
        .armed_o (timer_armed_o),
        .fire_o  (timer_fire)
    );

    trap_vector vec_i (
        .tvec (mtvec_q),
        .code (top_rec.code),
        .pc_o (vec_pc)
    );

    // Vector register: written only through the CSR port.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mtvec_q <= '0;
        else if (csr_we && csr_sel == SEL_TVEC) mtvec_q <= csr_wdata;
    end

    // Status fields: trap entry takes precedence over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            prev_en_q   <= 1'b0;
            prev_priv_q <= 2'b00;
        end else if (take) begin
            prev_en_q   <= en_q;
            prev_priv_q <= cur_priv;
            en_q        <= 1'b0;
        end else if (csr_we && csr_sel == SEL_STATUS) begin
            en_q        <= csr_wdata[EN_BIT];
            prev_en_q   <= csr_wdata[PREV_EN_BIT];
            prev_priv_q <= csr_wdata[PREV_PRIV_LSB +: 2];
        end
    end

    // Trap record registers and redirect strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_taken    <= 1'b0;
            redirect_pc   <= '0;
            redirect_priv <= 2'b00;
            mcause_o      <= '0;
            mepc_o        <= '0;
            mtval_o       <= '0;
        end else begin
            trap_taken <= take;
            if (take) begin
                redirect_pc   <= vec_pc;
                redirect_priv <= PRIV_MACH;
                mcause_o      <= {top_rec.is_irq, top_rec.cause};
                mepc_o        <= cur_pc;
                mtval_o       <= top_rec.tval;
            end
        end
    end

    // CSR read multiplexer.
    always_comb begin
        csr_rdata = '0;
        unique case (csr_sel)
            SEL_TVEC:   csr_rdata = mtvec_q;
            SEL_STATUS: begin
                csr_rdata[EN_BIT]              = en_q;
                csr_rdata[PREV_EN_BIT]         = prev_en_q;
                csr_rdata[PREV_PRIV_LSB +: 2]  = prev_priv_q;
            end
            SEL_CMP_LO: csr_rdata = tcmp_q[31:0];
            SEL_CMP_HI: csr_rdata = tcmp_q[63:32];
            default:    csr_rdata = '0;
        endcase
    end

    assign mie_o  = en_q;
    assign mpie_o = prev_en_q;
    assign mpp_o  = prev_priv_q;
endmodule

// File: rtl/trap_entry_chk.sv
// Protocol checker for trap_entry_ctrl, attached by bind. Observes ports and the
// vector and compare registers.
module trap_entry_chk
    import trap_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] cur_pc,
    input logic [1:0]      cur_priv,
    input logic            trap_taken,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      redirect_priv,
    input logic [XLEN-1:0] mepc_o,
    input logic            mie_o,
    input logic            mpie_o,
    input logic [1:0]      mpp_o,
    input logic            timer_armed_o,
    input logic            overflow_o,
    input logic [63:0]     mtime_o,
    input logic [63:0]     tcmp_q,
    input logic [XLEN-1:0] mtvec_q
);
    assert_take_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> $past(mie_o));

    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> !trap_taken);

    assert_status_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (!mie_o && mpie_o && mpp_o == $past(cur_priv)));

    assert_epc_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> mepc_o == $past(cur_pc));

    assert_machine_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> redirect_priv == PRIV_MACH);

    assert_direct_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && $past(mtvec_q[1:0]) != VEC_MODE) |-> redirect_pc == $past(mtvec_q));

    assert_vector_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && $past(mtvec_q[1:0]) == VEC_MODE) |-> redirect_pc[1:0] == 2'b00);

    assert_disarm_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timer_armed_o) |-> $past(tcmp_q < mtime_o));

    assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow_o) |-> overflow_o);
endmodule

bind trap_entry_ctrl trap_entry_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_pc        (cur_pc),
    .cur_priv      (cur_priv),
    .trap_taken    (trap_taken),
    .redirect_pc   (redirect_pc),
    .redirect_priv (redirect_priv),
    .mepc_o        (mepc_o),
    .mie_o         (mie_o),
    .mpie_o        (mpie_o),
    .mpp_o         (mpp_o),
    .timer_armed_o (timer_armed_o),
    .overflow_o    (overflow_o),
    .mtime_o       (mtime_o),
    .tcmp_q        (tcmp_q),
    .mtvec_q       (mtvec_q)
);

// File: tb/trap_entry_ctrl_tb_top.sv
// Self-checking bench: directed corners plus seeded random request bursts,
// compared against a model stack kept here.
module trap_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [1:0]  cur_priv = '0;
    logic        req_valid = 1'b0, req_irq = 1'b0;
    logic [4:0]  req_code = '0;
    logic [30:0] req_cause = '0;
    logic [31:0] req_tval = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata, redirect_pc, mcause_o, mepc_o, mtval_o;
    logic        trap_taken, mie_o, mpie_o, timer_armed_o, overflow_o;
    logic [1:0]  redirect_priv, mpp_o;
    logic [63:0] mtime_o;

    int checks = 0;
    int errors = 0;

    // model stack
    logic [68:0] m_stk [4];   // {irq, code[4:0], cause[30:0], tval[31:0]}
    int          m_cnt = 0;
    logic        m_ovf = 1'b0;
    logic [31:0] m_tvec = '0;

    always #4 clk = ~clk;

    trap_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_priv(cur_priv),
        .req_valid(req_valid), .req_irq(req_irq), .req_code(req_code),
        .req_cause(req_cause), .req_tval(req_tval), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_taken(trap_taken), .redirect_pc(redirect_pc),
        .redirect_priv(redirect_priv), .mcause_o(mcause_o), .mepc_o(mepc_o),
        .mtval_o(mtval_o), .mie_o(mie_o), .mpie_o(mpie_o), .mpp_o(mpp_o),
        .timer_armed_o(timer_armed_o), .overflow_o(overflow_o), .mtime_o(mtime_o)
    );

    function automatic logic [31:0] exp_target(input logic [31:0] tv, input logic [4:0] code);
        if (tv[1:0] == 2'b01) return {tv[31:2], 2'b00} + {25'd0, code, 2'b00};
        return tv;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
        if (sel == 2'd0) m_tvec = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic model_push(input logic [68:0] rec);
        if (m_cnt < 4) begin m_stk[m_cnt] = rec; m_cnt++; end
        else m_ovf = 1'b1;
    endtask

    task automatic push(input logic irq, input logic [4:0] code,
                        input logic [30:0] cause, input logic [31:0] tval);
        @(negedge clk);
        req_valid = 1'b1; req_irq = irq; req_code = code; req_cause = cause; req_tval = tval;
        model_push({irq, code, cause, tval});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Check the outputs on the strobe cycle against the model top, then pop it.
    task automatic check_entry(input logic [31:0] pc, input logic [1:0] pv);
        logic [68:0] r;
        r = m_stk[m_cnt - 1];
        m_cnt--;
        check("R1 strobe", {63'd0, trap_taken}, 64'd1);
        check("R2 status", {60'd0, mie_o, mpie_o, mpp_o}, {60'd0, 1'b0, 1'b1, pv});
        check("R3 mepc", {32'd0, mepc_o}, {32'd0, pc});
        check("R3 mcause", {32'd0, mcause_o}, {32'd0, r[68], r[62:32]});
        check("R3 mtval", {32'd0, mtval_o}, {32'd0, r[31:0]});
        check("R4 priv", {62'd0, redirect_priv}, 64'd3);
        check((m_tvec[1:0] == 2'b01) ? "R6 vectored pc" : "R5 direct pc",
              {32'd0, redirect_pc}, {32'd0, exp_target(m_tvec, r[67:63])});
        @(negedge clk);
        check("R1 strobe width", {63'd0, trap_taken}, 64'd0);
    endtask

    // Set the enable with a chosen PC/privilege and expect a trap next edge (R10 order).
    task automatic take_one(input logic [31:0] pc, input logic [1:0] pv);
        cur_pc = pc; cur_priv = pv;
        csr_write(2'd1, 32'h8);
        @(negedge clk);
        check_entry(pc, pv);
    endtask

    task automatic quiet_for(input int n, input string req);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin @(negedge clk); seen |= trap_taken; end
        check(req, {63'd0, seen}, 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] t0, cmpv;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // reset state
        check("R1 reset strobe", {63'd0, trap_taken}, 64'd0);
        check("R2 reset enable", {63'd0, mie_o}, 64'd0);
        check("R11 reset overflow", {63'd0, overflow_o}, 64'd0);
        check("R8 reset time", mtime_o, 64'd0);
        check("R9 reset armed", {63'd0, timer_armed_o}, 64'd0);
        rst_n = 1'b1;

        // R12 CSR readback
        csr_write(2'd0, 32'h0000_0100);
        csr_sel = 2'd0; #1;
        check("R12 tvec read", {32'd0, csr_rdata}, 64'h100);
        csr_write(2'd1, 32'h0000_1888);
        csr_sel = 2'd1; #1;
        check("R12 status read", {32'd0, csr_rdata}, 64'h1888);
        csr_write(2'd1, 32'h0);

        // R1: pending but disabled -> nothing
        push(1'b0, 5'd2, 31'd2, 32'hDEAD_0001);
        quiet_for(6, "R1 disabled no take");
        take_one(32'h0000_4000, 2'b00);

        // R1: enabled but empty -> nothing; then push while enabled
        csr_write(2'd1, 32'h8);
        quiet_for(5, "R1 empty no take");
        cur_pc = 32'h0000_5004; cur_priv = 2'b01;
        push(1'b1, 5'd11, 31'd11, 32'h0);
        @(negedge clk);
        check_entry(32'h0000_5004, 2'b01);

        // R10/R11: fill past depth, drain in reverse order
        csr_write(2'd0, 32'h0000_2001);
        for (int i = 0; i < 5; i++) push(1'b0, 5'(i + 1), 31'(i + 20), 32'(i * 16));
        @(negedge clk);
        check("R11 overflow set", {63'd0, overflow_o}, 64'd1);
        for (int i = 0; i < 4; i++) take_one(32'h100 + 32'(i * 4), 2'b11);
        check("R11 overflow sticky", {63'd0, overflow_o}, 64'd1);
        quiet_for(3, "R11 queue drained");

        // R5: mode 3 treated as direct
        csr_write(2'd0, 32'h0000_0203);
        push(1'b0, 5'd5, 31'd5, 32'h55);
        take_one(32'h0000_7000, 2'b00);

        // random bursts
        for (int r = 0; r < 30; r++) begin
            csr_write(2'd0, $urandom & 32'hFFFF_FFF3 | ($urandom % 4));
            for (int k = 0; k <= int'($urandom % 3); k++)
                push(1'($urandom), 5'($urandom), 31'($urandom), $urandom);
            while (m_cnt > 0) begin
                logic [1:0] pv;
                pv = ($urandom % 2 == 0) ? 2'b00 : 2'b11;
                take_one($urandom, pv);
            end
        end

        // R7/R9 timer
        csr_write(2'd0, 32'h0000_1001);
        csr_write(2'd3, 32'h0);
        check("R9 armed after write", {63'd0, timer_armed_o}, 64'd1);
        cmpv = {32'd0, mtime_o[31:0] + 32'd4};
        csr_write(2'd2, cmpv[31:0]);
        for (int i = 0; i < 200 && timer_armed_o; i++) @(negedge clk);
        check("R7 disarmed", {63'd0, timer_armed_o}, 64'd0);
        check("R7 fired after pass", {63'd0, mtime_o > cmpv}, 64'd1);
        model_push({1'b1, 5'd7, 31'd7, 32'd0});
        take_one(32'h0000_9000, 2'b00);
        csr_write(2'd1, 32'h8);
        quiet_for(30, "R7 no refire");
        csr_write(2'd1, 32'h0);

        // R8 time rate
        @(negedge clk);
        t0 = mtime_o;
        repeat (30) @(negedge clk);
        check("R8 rate", mtime_o - t0, 64'd10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule